// File: doc/BRIEF.md
# Byte-Lane Banked Word RAM

This block is the on-chip working memory of a 68000-style processor bus. It holds a RAM window split into four equal banks of 16-bit words. Each bank is made of two byte-wide synchronous memories: one serves the upper half of the data bus and the other serves the lower half. The processor can therefore write a single byte on either lane, or a whole word on both lanes, without touching anything else.

The main address decoder asserts `ram_sel` for the whole RAM window. Inside the block, a second decode picks one bank from two address bits. Each lane gets its own write enable, formed from the bank hit, the address strobe, the read/write line and that lane's data strobe.

Every memory performs a read on every clock. Read data appears on `bus_rdata` one clock after an address is presented. `bus_rdata` is gated by `rd_drive`, which stands in for a tri-state buffer enable and is high only during a read of this RAM. Accesses are zero-wait: `dtack_n` falls as soon as a valid address is seen.

With `BANK_AW` = 15, the block covers 128K words. Bank select then comes from byte-address bits [17:16] and the in-bank word from bits [15:1]. The default `BANK_AW` = 8 keeps the elaborated arrays small.

Top module: `banked_byte_ram`

## Requirements
- R1: The bank index is byte-address bits [BANK_AW+2:BANK_AW+1], and the in-bank word index is bits [BANK_AW:1]. Bit 0 and bits above the bank field are ignored. With BANK_AW = 15 these are bits [17:16] and [15:1].
- R2: No memory is written unless `ram_sel` = 1, `bus_as_n` = 0 and `bus_rw_n` = 0 on the same rising edge. Write attempts that miss any one of these leave the stored word unchanged.
- R3: A write with only `bus_uds_n` = 0 stores `bus_wdata[15:8]` into bits 15:8 of the addressed word. A write with only `bus_lds_n` = 0 stores `bus_wdata[7:0]` into bits 7:0. In both cases the other byte keeps its old value.
- R4: A write with both strobes low stores all 16 bits of `bus_wdata` in one clock.
- R5: A write cycle changes at most one bank. The same word index in the other banks is unchanged.
- R6: `rd_drive` equals `ram_sel & ~bus_as_n & bus_rw_n`, and `bus_rdata` is 16'h0000 whenever `rd_drive` is 0. In particular, nothing is driven during writes.
- R7: While `rd_drive` is 1, `bus_rdata` holds the word that the currently addressed bank contained at the word index sampled on the previous rising edge. This value is the stored content before any write made on that same edge.
- R8: `dtack_n` is 0 exactly while `ram_sel` = 1 and `bus_as_n` = 0, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_addr | input | 32 | Byte address from the processor |
| bus_wdata | input | 16 | Write data from the processor |
| bus_rw_n | input | 1 | 1 = read, 0 = write |
| bus_uds_n | input | 1 | Upper data strobe, active low, lane 15:8 |
| bus_lds_n | input | 1 | Lower data strobe, active low, lane 7:0 |
| bus_as_n | input | 1 | Address strobe, active low |
| ram_sel | input | 1 | RAM window select from the main decoder |
| bus_rdata | output | 16 | Read data toward the processor, zero when not driving |
| rd_drive | output | 1 | Read-bus drive enable |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The hardest case to reach from the ports is showing that a byte write left the other lane alone. Doing so requires a known value already in that lane, and the result can only be seen through a later full-word read, one clock behind the address. The bench first fills every word of every bank with a value that encodes its bank and index. It then applies single-lane writes of 0x55, 0xAA, 0xFF and 0x00, placing junk on the unused half of the data bus, and reads back full words. A behavioural model of every byte and every bank's read register is compared on every clock, so any spurious enable surfaces at the next read.

// File: rtl/banked_byte_ram.sv
module banked_byte_ram #(
  parameter int BANK_AW = 8,
  parameter int BSEL_W  = 2
) (
  input  logic        clk,
  input  logic [31:0] bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_rw_n,
  input  logic        bus_uds_n,
  input  logic        bus_lds_n,
  input  logic        bus_as_n,
  input  logic        ram_sel,
  output logic [15:0] bus_rdata,
  output logic        rd_drive,
  output logic        dtack_n
);
  localparam int NBANK = 1 << BSEL_W;
  localparam int DEPTH = 1 << BANK_AW;
  localparam int BLO   = BANK_AW + 1;
  localparam int BHI   = BANK_AW + BSEL_W;

  logic                 cyc;
  logic [BSEL_W-1:0]    bank_idx;
  logic [BANK_AW-1:0]   word_idx;
  logic [NBANK-1:0]     bank_hit, we_hi, we_lo;
  logic [NBANK-1:0][15:0] q_word;

  assign cyc      = ram_sel & ~bus_as_n;
  assign bank_idx = bus_addr[BHI:BLO];
  assign word_idx = bus_addr[BANK_AW:1];

  wire unused_addr_bits = ^{bus_addr[31:BHI+1], bus_addr[0]};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [7:0] m_hi [DEPTH];
    logic [7:0] m_lo [DEPTH];
    logic [7:0] q_hi, q_lo;

    assign bank_hit[b] = cyc && (bank_idx == BSEL_W'(b));
    assign we_hi[b]    = bank_hit[b] & ~bus_rw_n & ~bus_uds_n;
    assign we_lo[b]    = bank_hit[b] & ~bus_rw_n & ~bus_lds_n;

    always_ff @(posedge clk) begin
      if (we_hi[b]) m_hi[word_idx] <= bus_wdata[15:8];
      q_hi <= m_hi[word_idx];
    end

    always_ff @(posedge clk) begin
      if (we_lo[b]) m_lo[word_idx] <= bus_wdata[7:0];
      q_lo <= m_lo[word_idx];
    end

    assign q_word[b] = {q_hi, q_lo};
  end

  assign rd_drive  = cyc & bus_rw_n;
  assign bus_rdata = rd_drive ? q_word[bank_idx] : 16'h0000;
  assign dtack_n   = ~cyc;
endmodule

// File: rtl/banked_byte_ram_chk.sv
module banked_byte_ram_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          bus_rw_n,
  input logic          bus_uds_n,
  input logic          bus_lds_n,
  input logic          bus_as_n,
  input logic          ram_sel,
  input logic          rd_drive,
  input logic          dtack_n,
  input logic [NB-1:0] we_hi,
  input logic [NB-1:0] we_lo
);
  always @(posedge clk) begin
    assert_drive_only_on_read_R6: assert (!rd_drive || (bus_rw_n && ram_sel && !bus_as_n))
      else $error("rd_drive high outside a selected read");
    assert_no_write_without_cycle_R2: assert (!(bus_rw_n || bus_as_n || !ram_sel) || (we_hi == '0 && we_lo == '0))
      else $error("write enable outside a selected write");
    assert_hi_lane_needs_uds_R3: assert (!bus_uds_n || we_hi == '0)
      else $error("upper lane written without its strobe");
    assert_lo_lane_needs_lds_R3: assert (!bus_lds_n || we_lo == '0)
      else $error("lower lane written without its strobe");
    assert_single_bank_R5: assert ($onehot0(we_hi) && $onehot0(we_lo))
      else $error("more than one bank written");
    assert_dtack_needs_strobe_R8: assert (dtack_n || (!bus_as_n && ram_sel))
      else $error("dtack without a valid selected address");
  end
endmodule

bind banked_byte_ram banked_byte_ram_chk #(.NB(NBANK)) u_chk (
  .clk(clk), .bus_rw_n(bus_rw_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
  .bus_as_n(bus_as_n), .ram_sel(ram_sel), .rd_drive(rd_drive), .dtack_n(dtack_n),
  .we_hi(we_hi), .we_lo(we_lo)
);

// File: tb/banked_byte_ram_tb.sv
module banked_byte_ram_tb;
  localparam int AW = 8;
  localparam int NW = 1 << AW;
  localparam logic [31:0] BASE = 32'h0800_0000;

  logic        clk = 1'b0;
  logic [31:0] bus_addr = BASE;
  logic [15:0] bus_wdata = '0;
  logic        bus_rw_n = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1, bus_as_n = 1'b1, ram_sel = 1'b0;
  logic [15:0] bus_rdata;
  logic        rd_drive, dtack_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mh [4][NW];
  logic [7:0] ml [4][NW];
  logic [7:0] qmh [4];
  logic [7:0] qml [4];
  logic [15:0] last_rd;

  always #4 clk = ~clk;

  banked_byte_ram #(.BANK_AW(AW)) u_dut (
    .clk(clk), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rw_n(bus_rw_n),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_as_n(bus_as_n), .ram_sel(ram_sel),
    .bus_rdata(bus_rdata), .rd_drive(rd_drive), .dtack_n(dtack_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit sel, input bit as_n, input bit rw_n, input bit u_n, input bit l_n,
                      input int bank, input int word, input logic [15:0] data, input bit junk_hi);
    bit ed;
    @(negedge clk);
    ram_sel = sel; bus_as_n = as_n; bus_rw_n = rw_n; bus_uds_n = u_n; bus_lds_n = l_n;
    bus_addr = BASE | (32'(bank) << (AW + 1)) | (32'(word) << 1) | {31'(0), junk_hi};
    if (junk_hi) bus_addr[31:28] = 4'h3;
    bus_wdata = data;
    #1;
    ed = sel && !as_n && rw_n;
    chk("R6 drive", {15'(0), rd_drive}, {15'(0), ed});
    chk("R8 dtack", {15'(0), dtack_n}, {15'(0), !(sel && !as_n)});
    chk("R7 rdata", bus_rdata, ed ? {qmh[bank], qml[bank]} : 16'h0000);
    last_rd = bus_rdata;
    @(posedge clk);
    for (int b = 0; b < 4; b++) begin
      qmh[b] = mh[b][word];
      qml[b] = ml[b][word];
    end
    if (sel && !as_n && !rw_n) begin
      if (!u_n) mh[bank][word] = data[15:8];
      if (!l_n) ml[bank][word] = data[7:0];
    end
  endtask

  task automatic wr(input int bank, input int word, input logic [15:0] d, input bit u_n, input bit l_n);
    step(1, 0, 0, u_n, l_n, bank, word, d, 0);
  endtask

  task automatic rd_expect(input string tag, input int bank, input int word, input logic [15:0] exp);
    step(1, 0, 1, 0, 0, bank, word, 16'h0, 0);
    step(1, 0, 1, 0, 0, bank, word, 16'h0, 0);
    chk(tag, last_rd, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int w = 0; w < NW; w++) begin mh[b][w] = 0; ml[b][w] = 0; end
    for (int b = 0; b < 4; b++) begin qmh[b] = 0; qml[b] = 0; end
    step(0, 1, 1, 1, 1, 0, 0, 16'h0, 0);
    chk("R6 idle rdata", bus_rdata, 16'h0000);
    chk("R8 idle dtack", {15'(0), dtack_n}, 16'h0001);

    for (int b = 0; b < 4; b++) for (int w = 0; w < NW; w++)
      wr(b, w, 16'(b * 4096 + w), 0, 0);

    rd_expect("R1 bank2 word5", 2, 5, 16'h2005);
    rd_expect("R1 bank3 last word", 3, NW - 1, 16'h30FF);
    step(1, 0, 1, 0, 0, 1, 6, 16'h0, 1);
    step(1, 0, 1, 0, 0, 1, 6, 16'h0, 1);
    chk("R1 ignored addr bits", last_rd, 16'h1006);

    wr(1, 7, 16'h1234, 0, 0);
    rd_expect("R4 word write", 1, 7, 16'h1234);

    wr(1, 7, 16'h55EE, 0, 1);
    rd_expect("R3 upper 55", 1, 7, 16'h5534);
    wr(1, 7, 16'h11AA, 1, 0);
    rd_expect("R3 lower AA", 1, 7, 16'h55AA);
    wr(1, 7, 16'hFF22, 0, 1);
    rd_expect("R3 upper FF", 1, 7, 16'hFFAA);
    wr(1, 7, 16'h3300, 1, 0);
    rd_expect("R3 lower 00", 1, 7, 16'hFF00);

    step(0, 0, 0, 0, 0, 1, 7, 16'hDEAD, 0);
    rd_expect("R2 no ram_sel", 1, 7, 16'hFF00);
    step(1, 1, 0, 0, 0, 1, 7, 16'hDEAD, 0);
    rd_expect("R2 no strobe", 1, 7, 16'hFF00);
    step(1, 0, 1, 0, 0, 1, 7, 16'hDEAD, 0);
    rd_expect("R2 read cycle", 1, 7, 16'hFF00);
    step(1, 0, 0, 1, 1, 1, 7, 16'hDEAD, 0);
    rd_expect("R2 no data strobe", 1, 7, 16'hFF00);

    wr(2, 9, 16'hA0B2, 0, 0);
    rd_expect("R5 bank2 new", 2, 9, 16'hA0B2);
    rd_expect("R5 bank0 kept", 0, 9, 16'h0009);
    rd_expect("R5 bank1 kept", 1, 9, 16'h1009);
    rd_expect("R5 bank3 kept", 3, 9, 16'h3009);

    step(1, 0, 1, 0, 0, 0, 20, 16'h0, 0);
    step(1, 0, 1, 0, 0, 3, 20, 16'h0, 0);
    chk("R7 bank switch", last_rd, 16'h3014);
    wr(0, 20, 16'h7777, 0, 0);
    step(1, 0, 1, 0, 0, 0, 20, 16'h0, 0);
    chk("R7 old data on write edge", last_rd, 16'h0014);
    step(1, 0, 1, 0, 0, 0, 20, 16'h0, 0);
    chk("R7 new data next", last_rd, 16'h7777);

    step(0, 1, 1, 1, 1, 0, 0, 16'h0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule